// File: doc/BRIEF.md
# Bulk List Current-Pointer Manager

This block keeps the working position of a USB host controller inside its bulk endpoint-descriptor list. The list-processing engine tells it when a descriptor has been served, and gives the link to the next descriptor. It also tells it when the walk has hit the tail of the list. The stored pointer persists between frames, so the next frame picks up exactly where the previous one stopped and does not go back to the head.

At the tail, the block checks the list-filled flag. When the flag is set, it reloads the pointer from the list head and pulses a clear request back to the control register. When the flag is clear, the pointer stays where it is. Host software can read the pointer at any time. Software can replace the pointer only while the list is disabled; writes that arrive while the list is running are dropped. Descriptors sit on 16-byte boundaries, so the four low pointer bits are always held at zero. A zero pointer means the end of the list, and zero is also the reset value.

Top module: `bulk_ptr_mgr`

## Requirements
- R1: After reset, `cur_ptr_o` is 0 and `filled_clr_o` is 0.
- R2: With `list_en_i`=1, a cycle with `served_i`=1, a nonzero `next_ptr_i` and `eol_i`=0 loads `next_ptr_i` into the pointer, with bits 3:0 forced to 0, at the next clock edge.
- R3: In a cycle with no served event, no tail event and no accepted write, the pointer holds its value. The walk therefore resumes from the stored pointer across frames.
- R4: With `list_en_i`=1, a tail condition occurs when `eol_i`=1, or when `served_i`=1 with `next_ptr_i`=0. If `list_filled_i`=1 in that cycle, the pointer takes `head_ptr_i` with bits 3:0 forced to 0 at the next edge. In the same cycle, `filled_clr_o` is 1; it is 0 again in the following cycle.
- R5: A tail condition with `list_filled_i`=0 leaves the pointer unchanged and keeps `filled_clr_o` at 0.
- R6: With `list_en_i`=0, `sw_wr_i`=1 loads `sw_wdata_i`, with bits 3:0 forced to 0, at the next edge.
- R7: With `list_en_i`=1, `sw_wr_i` has no effect on the pointer.
- R8: `sw_rdata_o` always equals the current pointer value `cur_ptr_o`.
- R9: With `list_en_i`=0, `served_i` and `eol_i` have no effect on the pointer and `filled_clr_o` stays 0.
- R10: Bits 3:0 of `cur_ptr_o` are 0 in every cycle.
- R11: When a served event with a nonzero next pointer and `eol_i` coincide, the tail handling of R4/R5 wins over the advance of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| served_i | input | 1 | Engine finished the current descriptor |
| next_ptr_i | input | 32 | Link to the next descriptor of the served one |
| eol_i | input | 1 | Engine reached the tail of the list |
| head_ptr_i | input | 32 | Head pointer of the bulk list |
| list_en_i | input | 1 | Bulk list enable |
| list_filled_i | input | 1 | Bulk list filled flag |
| sw_wr_i | input | 1 | Software write strobe for the pointer |
| sw_wdata_i | input | 32 | Software write data |
| sw_rdata_o | output | 32 | Software read value of the pointer |
| cur_ptr_o | output | 32 | Current descriptor pointer to the engine |
| filled_clr_o | output | 1 | One-cycle request to clear the filled flag |

## Verification
A wrong action choice shows up on `cur_ptr_o` and `sw_rdata_o` one clock after the triggering event. A wrong reload decision also shows up on `filled_clr_o` in the event cycle itself, so a misread filled flag is visible before the clock edge. A pointer that loses its 16-byte alignment breaks the zero low-bit rule at once, on the first edge after the bad load. A write that slips through while the list is enabled changes the read value on the next cycle.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_ADV    = 2'd1,
        ACT_RELOAD = 2'd2,
        ACT_SWWR   = 2'd3
    } bpm_act_e;
endpackage

// File: rtl/bpm_action_sel.sv
module bpm_action_sel #(
    parameter int PTR_W = 32
) (
    input  logic              served_i,
    input  logic [PTR_W-1:0]  next_ptr_i,
    input  logic              eol_i,
    input  logic              list_en_i,
    input  logic              list_filled_i,
    input  logic              sw_wr_i,
    output bpm_pkg::bpm_act_e act_o
);
    import bpm_pkg::*;

    logic link_null;
    logic tail_hit;

    always_comb begin
        link_null = (next_ptr_i == '0);
        tail_hit  = eol_i || (served_i && link_null);
        act_o     = ACT_HOLD;
        if (list_en_i) begin
            // tail handling takes priority over the advance (R11)
            if (tail_hit) begin
                act_o = list_filled_i ? ACT_RELOAD : ACT_HOLD;
            end else if (served_i) begin
                act_o = ACT_ADV;
            end
        end else if (sw_wr_i) begin
            act_o = ACT_SWWR;
        end
    end
endmodule

// File: rtl/bpm_ptr_store.sv
module bpm_ptr_store #(
    parameter int PTR_W      = 32,
    parameter int ALIGN_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bpm_pkg::bpm_act_e act_i,
    input  logic [PTR_W-1:0]  next_ptr_i,
    input  logic [PTR_W-1:0]  head_ptr_i,
    input  logic [PTR_W-1:0]  wdata_i,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              clr_o
);
    import bpm_pkg::*;

    localparam int HI_W = PTR_W - ALIGN_BITS;

    typedef struct packed {
        logic [HI_W-1:0] ptr_hi;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (act_i)
            ACT_ADV:    st_d.ptr_hi = next_ptr_i[PTR_W-1:ALIGN_BITS];
            ACT_RELOAD: st_d.ptr_hi = head_ptr_i[PTR_W-1:ALIGN_BITS];
            ACT_SWWR:   st_d.ptr_hi = wdata_i[PTR_W-1:ALIGN_BITS];
            default:    st_d.ptr_hi = st_q.ptr_hi;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_o = {st_q.ptr_hi, {ALIGN_BITS{1'b0}}};
    assign clr_o = (act_i == ACT_RELOAD);

    a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_o[ALIGN_BITS-1:0] == '0);
endmodule

// File: rtl/bulk_ptr_mgr.sv
module bulk_ptr_mgr #(
    parameter int PTR_W      = 32,
    parameter int ALIGN_BITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             served_i,
    input  logic [PTR_W-1:0] next_ptr_i,
    input  logic             eol_i,
    input  logic [PTR_W-1:0] head_ptr_i,
    input  logic             list_en_i,
    input  logic             list_filled_i,
    input  logic             sw_wr_i,
    input  logic [PTR_W-1:0] sw_wdata_i,
    output logic [PTR_W-1:0] sw_rdata_o,
    output logic [PTR_W-1:0] cur_ptr_o,
    output logic             filled_clr_o
);
    import bpm_pkg::*;

    localparam logic [PTR_W-1:0] LOW_MASK = PTR_W'((1 << ALIGN_BITS) - 1);

    bpm_act_e act;

    bpm_action_sel #(.PTR_W(PTR_W)) u_sel (
        .served_i      (served_i),
        .next_ptr_i    (next_ptr_i),
        .eol_i         (eol_i),
        .list_en_i     (list_en_i),
        .list_filled_i (list_filled_i),
        .sw_wr_i       (sw_wr_i),
        .act_o         (act)
    );

    bpm_ptr_store #(.PTR_W(PTR_W), .ALIGN_BITS(ALIGN_BITS)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_i      (act),
        .next_ptr_i (next_ptr_i),
        .head_ptr_i (head_ptr_i),
        .wdata_i    (sw_wdata_i),
        .ptr_o      (cur_ptr_o),
        .clr_o      (filled_clr_o)
    );

    assign sw_rdata_o = cur_ptr_o;

    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (list_en_i && served_i && !eol_i && next_ptr_i != '0)
        |=> cur_ptr_o == ($past(next_ptr_i) & ~LOW_MASK));

    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (list_en_i && list_filled_i && (eol_i || (served_i && next_ptr_i == '0)))
        |=> cur_ptr_o == ($past(head_ptr_i) & ~LOW_MASK));

    a_r4_clr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        filled_clr_o |-> (list_en_i && list_filled_i));

    a_r5_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (list_en_i && !list_filled_i && (eol_i || (served_i && next_ptr_i == '0)))
        |=> $stable(cur_ptr_o));

    a_r6_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!list_en_i && sw_wr_i) |=> cur_ptr_o == ($past(sw_wdata_i) & ~LOW_MASK));

    a_r9_disabled_events: assert property (@(posedge clk) disable iff (!rst_n)
        (!list_en_i && !sw_wr_i) |=> $stable(cur_ptr_o));

    a_r8_readback: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rdata_o == cur_ptr_o);
endmodule

// File: tb/sim_bulk_ptr_mgr.sv
module sim_bulk_ptr_mgr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        served_i = 1'b0;
    logic [31:0] next_ptr_i = '0;
    logic        eol_i = 1'b0;
    logic [31:0] head_ptr_i = '0;
    logic        list_en_i = 1'b0;
    logic        list_filled_i = 1'b0;
    logic        sw_wr_i = 1'b0;
    logic [31:0] sw_wdata_i = '0;
    logic [31:0] sw_rdata_o;
    logic [31:0] cur_ptr_o;
    logic        filled_clr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bulk_ptr_mgr u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        served_i = 0; eol_i = 0; sw_wr_i = 0; next_ptr_i = '0;
    endtask

    // drive one event cycle, check the clear pulse before the edge
    task automatic event_cycle(input logic srv, input logic [31:0] nxt, input logic eol,
                               input string req, input logic exp_clr);
        @(negedge clk);
        served_i = srv; next_ptr_i = nxt; eol_i = eol;
        #1 chk(req, {31'b0, filled_clr_o}, {31'b0, exp_clr});
        @(posedge clk); #1;
        idle_inputs();
        #1 chk(req, {31'b0, filled_clr_o}, 32'd0);
    endtask

    task automatic sw_write(input logic [31:0] d);
        @(negedge clk);
        sw_wr_i = 1; sw_wdata_i = d;
        @(posedge clk); #1;
        sw_wr_i = 0;
    endtask

    task automatic t_reset();
        chk("R1 ptr", cur_ptr_o, 32'd0);
        chk("R1 clr", {31'b0, filled_clr_o}, 32'd0);
        chk("R8 read", sw_rdata_o, 32'd0);
    endtask

    task automatic t_sw_disabled();
        list_en_i = 0;
        sw_write(32'h1234_5678);
        chk("R6 write", cur_ptr_o, 32'h1234_5670);
        chk("R10 low bits", {28'b0, cur_ptr_o[3:0]}, 32'd0);
        chk("R8 read", sw_rdata_o, 32'h1234_5670);
    endtask

    task automatic t_sw_enabled();
        list_en_i = 1;
        sw_write(32'hDEAD_BEE0);
        chk("R7 ignored", sw_rdata_o, 32'h1234_5670);
    endtask

    task automatic t_advance();
        list_en_i = 1; list_filled_i = 1;
        event_cycle(1, 32'hA0B0_C0D7, 0, "R2 no clr", 0);
        chk("R2 advance", cur_ptr_o, 32'hA0B0_C0D0);
        chk("R10 low bits", {28'b0, cur_ptr_o[3:0]}, 32'd0);
        repeat (5) @(posedge clk);
        #1 chk("R3 hold", cur_ptr_o, 32'hA0B0_C0D0);
    endtask

    task automatic t_tail_unfilled();
        list_en_i = 1; list_filled_i = 0; head_ptr_i = 32'h0000_5550;
        event_cycle(0, 32'd0, 1, "R5 clr", 0);
        chk("R5 eol hold", cur_ptr_o, 32'hA0B0_C0D0);
        event_cycle(1, 32'd0, 0, "R5 clr null", 0);
        chk("R5 null hold", cur_ptr_o, 32'hA0B0_C0D0);
    endtask

    task automatic t_tail_filled();
        list_en_i = 1; list_filled_i = 1; head_ptr_i = 32'h0000_1009;
        event_cycle(0, 32'd0, 1, "R4 clr eol", 1);
        chk("R4 reload eol", cur_ptr_o, 32'h0000_1000);
        event_cycle(1, 32'h0000_2220, 0, "R2 adv", 0);
        chk("R2 adv2", cur_ptr_o, 32'h0000_2220);
        head_ptr_i = 32'h00C0_0040;
        event_cycle(1, 32'd0, 0, "R4 clr null", 1);
        chk("R4 reload null", cur_ptr_o, 32'h00C0_0040);
    endtask

    task automatic t_priority();
        list_en_i = 1; list_filled_i = 1; head_ptr_i = 32'h0BAD_0010;
        event_cycle(1, 32'h7777_7770, 1, "R11 clr", 1);
        chk("R11 tail wins", cur_ptr_o, 32'h0BAD_0010);
        list_filled_i = 0;
        event_cycle(1, 32'h6666_6660, 1, "R11 clr unfilled", 0);
        chk("R11 tail hold", cur_ptr_o, 32'h0BAD_0010);
    endtask

    task automatic t_disabled_events();
        list_en_i = 0; list_filled_i = 1; head_ptr_i = 32'h0000_0F00;
        event_cycle(1, 32'h3333_3330, 0, "R9 clr srv", 0);
        chk("R9 served ignored", cur_ptr_o, 32'h0BAD_0010);
        event_cycle(0, 32'd0, 1, "R9 clr eol", 0);
        chk("R9 eol ignored", cur_ptr_o, 32'h0BAD_0010);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 t_reset();
        @(negedge clk) rst_n = 1;
        @(posedge clk); #1;
        t_reset();
        t_sw_disabled();
        t_sw_enabled();
        t_advance();
        t_tail_unfilled();
        t_tail_filled();
        t_priority();
        t_disabled_events();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule